// File: doc/BRIEF.md
# LIN Slave Break Detector with Receiver Flags

This block is the receive side of a UART used as a LIN slave. It samples the serial line once per bit time, on a single-cycle bit-rate enable, and runs two functions side by side. The first is a small character receiver: a start bit, eight data bits sent LSB first, an optional even parity bit, and one stop bit. It keeps a data register and four status flags: data-register-full, framing error, overrun error and parity error. The second is a break detector. It counts consecutive low samples and, after a dominant period far longer than any legal character, sets a sticky break flag that software clears with a strobe.

A LIN synch break has every data bit low and a low stop bit, so the receiver always reports a framing error before the break is declared. In the 8N1 format the framing error comes exactly two bit times earlier. A configuration input chooses whether a detected break clears the four receive flags or leaves them alone. Break detection runs only in the operation modes that a parameter mask marks as LIN modes. In those modes the raw line is also passed to a capture-timer output, so that the synch field that follows the break can be timed. In any other mode that output rests high.

Top module: `lin_brk_rx`

## Requirements
- R1: A frame made of a low start sample, DATA_BITS data samples (LSB first) and a high stop sample loads the data register and sets rdrf, in the cycle after the stop-bit tick. A one-cycle rdAck clears rdrf, fre, ore and pe.
- R2: If the stop-bit sample is low, fre is set together with the end of the frame, and the byte is still delivered.
- R3: If a frame completes while rdrf is already set, ore is set and the data register keeps its previous byte.
- R4: With parEn = 1, one parity sample follows the data samples. pe is set when that sample differs from the XOR of the data bits (even parity).
- R5: In a LIN mode, brkFlag is set in the cycle after the 12th consecutive low sample. That is 11 bit times after the sample of the falling edge. Any high sample restarts the count.
- R6: brkIrq equals brkIntEn AND brkFlag. rxIrq equals rxIntEn AND (rdrf OR fre OR ore OR pe).
- R7: In 8N1 with reception enabled, a break makes rxIrq rise after the 10th low sample. That is two ticks before brkIrq rises.
- R8: brkFlag never sets when MODE_MASK[opMode] is 0. The default mask marks modes 0 and 3 as LIN modes.
- R9: When clrOnBrk = 1, the tick that detects a break also clears rdrf, fre, ore and pe. When clrOnBrk = 0, those flags are left unchanged.
- R10: brkFlag stays set until a brkClr strobe. If brkClr arrives in the same cycle as a new detection, the flag ends up set.
- R11: One unbroken low period sets brkFlag at most once. Detection re-arms only after at least one high sample.
- R12: While rxEn = 0 the receiver sets no flag, and break detection keeps running.
- R13: capOut equals serIn in a LIN mode and is 1 in any other mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| bitTick | input | 1 | One-cycle enable, once per bit time |
| serIn | input | 1 | Serial line, synchronous to clk |
| rxEn | input | 1 | Reception enable |
| parEn | input | 1 | Adds an even parity bit to the frame |
| rxIntEn | input | 1 | Receive interrupt enable |
| brkIntEn | input | 1 | Break interrupt enable |
| opMode | input | 2 | Operation mode, looked up in MODE_MASK |
| clrOnBrk | input | 1 | A break clears the receive flags when 1 |
| rdAck | input | 1 | Data-read strobe, clears the receive flags |
| brkClr | input | 1 | Clear strobe for brkFlag |
| rxData | output | 8 | Received data register |
| rdrf | output | 1 | Data register full |
| fre | output | 1 | Framing error |
| ore | output | 1 | Overrun error |
| pe | output | 1 | Parity error |
| brkFlag | output | 1 | Break detected, sticky |
| rxIrq | output | 1 | Receive interrupt request |
| brkIrq | output | 1 | Break interrupt request |
| capOut | output | 1 | Gated line copy for a capture timer |

## Verification
Two pairs of actions can land in one cycle. A break detection can coincide with a software clear of the break flag, and the break tick can clear the receive flags that the framing error set two ticks earlier. The bench provokes the first by driving brkClr together with the 12th low tick while the flag is already set, and judges it by the flag still reading 1 afterwards. For the second, it records the tick index at which each interrupt first reads high during a 13-bit break. It expects 10 and 12, and then checks the receive flags under both settings of clrOnBrk.

// File: rtl/lin_brk_pkg.sv
package lin_brk_pkg;

  typedef enum logic [2:0] {
    RX_WAIT,
    RX_IDLE,
    RX_DATA,
    RX_PAR,
    RX_STOP
  } rxState_t;

  typedef struct packed {
    logic shift;
    logic parCap;
    logic done;
    logic stopLow;
    logic brkHit;
  } lbdStrobe_t;

endpackage

// File: rtl/lin_brk_ctrl.sv
module lin_brk_ctrl
  import lin_brk_pkg::*;
#(
  parameter int DATA_BITS = 8,
  parameter int BRK_LEN   = 11,
  parameter int MODE_W    = 2,
  parameter logic [(1<<MODE_W)-1:0] MODE_MASK = 4'b1001
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitTick,
  input  logic              serIn,
  input  logic              rxEn,
  input  logic              parEn,
  input  logic [MODE_W-1:0] opMode,
  output lbdStrobe_t        stb,
  output logic              modeOk
);

  localparam int BIT_W   = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
  localparam int LOW_W   = $clog2(BRK_LEN + 2);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_BITS - 1);
  localparam logic [LOW_W-1:0] LOW_HIT  = LOW_W'(BRK_LEN);
  localparam logic [LOW_W-1:0] LOW_MAX  = LOW_W'(BRK_LEN + 1);

  rxState_t         state;
  logic [BIT_W-1:0] bitCnt;
  logic [LOW_W-1:0] lowCnt;
  logic             activeTick;

  assign modeOk     = MODE_MASK[opMode];
  assign activeTick = rxEn & bitTick;

  // receiver sequencing
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= RX_WAIT;
      bitCnt <= '0;
    end else if (!rxEn) begin
      state  <= RX_WAIT;
      bitCnt <= '0;
    end else if (bitTick) begin
      case (state)
        RX_WAIT: if (serIn) state <= RX_IDLE;
        RX_IDLE: if (!serIn) begin
          state  <= RX_DATA;
          bitCnt <= '0;
        end
        RX_DATA: begin
          bitCnt <= bitCnt + 1'b1;
          if (bitCnt == LAST_BIT) state <= parEn ? RX_PAR : RX_STOP;
        end
        RX_PAR:  state <= RX_STOP;
        RX_STOP: state <= serIn ? RX_IDLE : RX_WAIT;
        default: state <= RX_WAIT;
      endcase
    end
  end

  // consecutive-low counter, saturating so one low period hits once
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowCnt <= '0;
    end else if (bitTick) begin
      if (serIn)               lowCnt <= '0;
      else if (lowCnt != LOW_MAX) lowCnt <= lowCnt + 1'b1;
    end
  end

  always_comb begin
    stb.shift   = activeTick && (state == RX_DATA);
    stb.parCap  = activeTick && (state == RX_PAR);
    stb.done    = activeTick && (state == RX_STOP);
    stb.stopLow = !serIn;
    stb.brkHit  = bitTick && !serIn && modeOk && (lowCnt == LOW_HIT);
  end

endmodule

// File: rtl/lin_brk_dp.sv
module lin_brk_dp
  import lin_brk_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 serIn,
  input  logic                 parEn,
  input  logic                 clrOnBrk,
  input  logic                 rdAck,
  input  logic                 brkClr,
  input  logic                 rxIntEn,
  input  logic                 brkIntEn,
  input  logic                 modeOk,
  input  lbdStrobe_t           stb,
  output logic [DATA_BITS-1:0] rxData,
  output logic                 rdrf,
  output logic                 fre,
  output logic                 ore,
  output logic                 pe,
  output logic                 brkFlag,
  output logic                 rxIrq,
  output logic                 brkIrq,
  output logic                 capOut
);

  logic [DATA_BITS-1:0] shiftReg;
  logic                 parBit;
  logic                 rdrfN, freN, oreN, peN;
  logic [DATA_BITS-1:0] dataN;
  logic                 parBad;

  assign parBad = parEn && (parBit != ^shiftReg);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      parBit   <= 1'b0;
    end else begin
      if (stb.shift)  shiftReg <= {serIn, shiftReg[DATA_BITS-1:1]};
      if (stb.parCap) parBit   <= serIn;
    end
  end

  // flag update: read ack, then frame end, then break clear
  always_comb begin
    rdrfN = rdrf;
    freN  = fre;
    oreN  = ore;
    peN   = pe;
    dataN = rxData;
    if (rdAck) begin
      rdrfN = 1'b0;
      freN  = 1'b0;
      oreN  = 1'b0;
      peN   = 1'b0;
    end
    if (stb.done) begin
      if (rdrfN) begin
        oreN = 1'b1;
      end else begin
        dataN = shiftReg;
        rdrfN = 1'b1;
      end
      if (stb.stopLow) freN = 1'b1;
      if (parBad)      peN  = 1'b1;
    end
    if (stb.brkHit && clrOnBrk) begin
      rdrfN = 1'b0;
      freN  = 1'b0;
      oreN  = 1'b0;
      peN   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData  <= '0;
      rdrf    <= 1'b0;
      fre     <= 1'b0;
      ore     <= 1'b0;
      pe      <= 1'b0;
      brkFlag <= 1'b0;
    end else begin
      rxData <= dataN;
      rdrf   <= rdrfN;
      fre    <= freN;
      ore    <= oreN;
      pe     <= peN;
      if (stb.brkHit)  brkFlag <= 1'b1;
      else if (brkClr) brkFlag <= 1'b0;
    end
  end

  assign rxIrq  = rxIntEn && (rdrf || fre || ore || pe);
  assign brkIrq = brkIntEn && brkFlag;
  assign capOut = modeOk ? serIn : 1'b1;

endmodule

// File: rtl/lin_brk_rx.sv
module lin_brk_rx
  import lin_brk_pkg::*;
#(
  parameter int DATA_BITS = 8,
  parameter int BRK_LEN   = 11,
  parameter int MODE_W    = 2,
  parameter logic [(1<<MODE_W)-1:0] MODE_MASK = 4'b1001
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 bitTick,
  input  logic                 serIn,
  input  logic                 rxEn,
  input  logic                 parEn,
  input  logic                 rxIntEn,
  input  logic                 brkIntEn,
  input  logic [MODE_W-1:0]    opMode,
  input  logic                 clrOnBrk,
  input  logic                 rdAck,
  input  logic                 brkClr,
  output logic [DATA_BITS-1:0] rxData,
  output logic                 rdrf,
  output logic                 fre,
  output logic                 ore,
  output logic                 pe,
  output logic                 brkFlag,
  output logic                 rxIrq,
  output logic                 brkIrq,
  output logic                 capOut
);

  lbdStrobe_t stb;
  logic       modeOk;

  lin_brk_ctrl #(
    .DATA_BITS(DATA_BITS), .BRK_LEN(BRK_LEN),
    .MODE_W(MODE_W), .MODE_MASK(MODE_MASK)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .serIn(serIn),
    .rxEn(rxEn), .parEn(parEn), .opMode(opMode),
    .stb(stb), .modeOk(modeOk)
  );

  lin_brk_dp #(.DATA_BITS(DATA_BITS)) uDp (
    .clk(clk), .rstN(rstN), .serIn(serIn), .parEn(parEn),
    .clrOnBrk(clrOnBrk), .rdAck(rdAck), .brkClr(brkClr),
    .rxIntEn(rxIntEn), .brkIntEn(brkIntEn), .modeOk(modeOk),
    .stb(stb), .rxData(rxData), .rdrf(rdrf), .fre(fre), .ore(ore),
    .pe(pe), .brkFlag(brkFlag), .rxIrq(rxIrq), .brkIrq(brkIrq),
    .capOut(capOut)
  );

endmodule

// File: rtl/lin_brk_chk.sv
module lin_brk_chk #(
  parameter int MODE_W = 2,
  parameter logic [(1<<MODE_W)-1:0] MODE_MASK = 4'b1001
) (
  input logic              clk,
  input logic              rstN,
  input logic              bitTick,
  input logic              serIn,
  input logic              rxEn,
  input logic [MODE_W-1:0] opMode,
  input logic              clrOnBrk,
  input logic              brkClr,
  input logic              rdrf,
  input logic              fre,
  input logic              ore,
  input logic              pe,
  input logic              brkFlag
);

  // R5
  brk_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(brkFlag) |-> $past(bitTick && !serIn));

  // R8
  brk_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(brkFlag) |-> $past(MODE_MASK[opMode]));

  // R10
  brk_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (brkFlag && !brkClr) |=> brkFlag);

  // R9
  brk_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(brkFlag) && $past(clrOnBrk)) |-> !(rdrf || fre || ore || pe));

  // R12
  rx_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!rxEn && !fre && !rdrf) |=> (!fre && !rdrf));

endmodule

bind lin_brk_rx lin_brk_chk #(.MODE_W(MODE_W), .MODE_MASK(MODE_MASK)) uChk (
  .clk(clk), .rstN(rstN), .bitTick(bitTick), .serIn(serIn), .rxEn(rxEn),
  .opMode(opMode), .clrOnBrk(clrOnBrk), .brkClr(brkClr), .rdrf(rdrf),
  .fre(fre), .ore(ore), .pe(pe), .brkFlag(brkFlag)
);

// File: tb/sim_lin_brk_rx.sv
module sim_lin_brk_rx;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       bitTick = 1'b0, serIn = 1'b1, rxEn = 1'b0, parEn = 1'b0;
  logic       rxIntEn = 1'b0, brkIntEn = 1'b0, clrOnBrk = 1'b0;
  logic       rdAck = 1'b0, brkClr = 1'b0;
  logic [1:0] opMode = 2'd0;
  logic [7:0] rxData;
  logic       rdrf, fre, ore, pe, brkFlag, rxIrq, brkIrq, capOut;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  int rxFirst, brkFirst;

  lin_brk_rx u0 (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .serIn(serIn), .rxEn(rxEn),
    .parEn(parEn), .rxIntEn(rxIntEn), .brkIntEn(brkIntEn), .opMode(opMode),
    .clrOnBrk(clrOnBrk), .rdAck(rdAck), .brkClr(brkClr), .rxData(rxData),
    .rdrf(rdrf), .fre(fre), .ore(ore), .pe(pe), .brkFlag(brkFlag),
    .rxIrq(rxIrq), .brkIrq(brkIrq), .capOut(capOut)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 190000) begin
      fails = fails + 1;
      $display("FAIL watchdog: run hung, got %0d cycles, expected fewer", cycles);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests = tests + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // one bit time: two idle cycles, then a tick; returns at the negedge after it
  task automatic tick(input logic v, input logic clr = 1'b0);
    repeat (2) @(negedge clk);
    serIn   = v;
    bitTick = 1'b1;
    brkClr  = clr;
    @(negedge clk);
    bitTick = 1'b0;
    brkClr  = 1'b0;
  endtask

  task automatic pulseAck();
    rdAck = 1'b1;
    @(negedge clk);
    rdAck = 1'b0;
  endtask

  task automatic pulseClr();
    brkClr = 1'b1;
    @(negedge clk);
    brkClr = 1'b0;
  endtask

  task automatic sendFrame(input logic [7:0] b, input logic withPar,
                           input logic parFlip, input logic stopV);
    tick(1'b0);
    for (int i = 0; i < 8; i++) tick(b[i]);
    if (withPar) tick((^b) ^ parFlip);
    tick(stopV);
  endtask

  // n low ticks, recording the first tick after which each interrupt is high
  task automatic lowRun(input int n);
    rxFirst = 0;
    brkFirst = 0;
    for (int k = 1; k <= n; k++) begin
      tick(1'b0);
      if (rxIrq && rxFirst == 0) rxFirst = k;
      if (brkIrq && brkFirst == 0) brkFirst = k;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 reset flags", {rdrf, fre, ore, pe, brkFlag, rxIrq, brkIrq}, 7'b0);
    check("R13 reset capOut", capOut, 1'b1);

    rxEn = 1'b1; rxIntEn = 1'b1; brkIntEn = 1'b1;
    tick(1'b1); tick(1'b1);

    // R1 sweep of every byte in 8N1
    for (int b = 0; b < 256; b++) begin
      sendFrame(8'(b), 1'b0, 1'b0, 1'b1);
      check("R1 byte data", rxData, 32'(b));
      check("R1 byte flags", {rdrf, fre, ore, pe}, 4'b1000);
      pulseAck();
      tick(1'b1);
    end
    check("R1 ack clears", {rdrf, fre, ore, pe}, 4'b0);

    // R4 sweep with parity, odd bytes carry a wrong parity bit
    parEn = 1'b1;
    for (int b = 0; b < 256; b++) begin
      sendFrame(8'(b), 1'b1, b[0], 1'b1);
      check("R4 parity data", rxData, 32'(b));
      check("R4 parity flag", pe, b[0]);
      pulseAck();
      tick(1'b1);
    end
    parEn = 1'b0;

    // R3 overrun
    sendFrame(8'hA5, 1'b0, 1'b0, 1'b1);
    tick(1'b1);
    sendFrame(8'h3C, 1'b0, 1'b0, 1'b1);
    check("R3 overrun flag", {rdrf, ore}, 2'b11);
    check("R3 data kept", rxData, 8'hA5);
    pulseAck();
    tick(1'b1);

    // R2 framing error
    sendFrame(8'h55, 1'b0, 1'b0, 1'b0);
    check("R2 framing flag", {rdrf, fre}, 2'b11);
    check("R2 framing data", rxData, 8'h55);
    check("R6 rxIrq on error", rxIrq, 1'b1);
    tick(1'b1);
    check("R2 no break", brkFlag, 1'b0);
    pulseAck();
    tick(1'b1);

    // R7 R5 R9 break, flags kept
    opMode = 2'd0; clrOnBrk = 1'b0;
    check("R13 capOut high", capOut, 1'b1);
    lowRun(13);
    check("R13 capOut follows low", capOut, 1'b0);
    check("R7 rxIrq tick", rxFirst, 10);
    check("R5 brkIrq tick", brkFirst, 12);
    check("R9 flags kept", {rdrf, fre}, 2'b11);
    tick(1'b1);
    check("R10 flag held", brkFlag, 1'b1);
    pulseClr();
    check("R10 clear strobe", brkFlag, 1'b0);
    check("R6 brkIrq drops", brkIrq, 1'b0);
    pulseAck();
    tick(1'b1);

    // R9 break clears flags, mode 3
    opMode = 2'd3; clrOnBrk = 1'b1;
    lowRun(13);
    check("R7 rxIrq tick mode3", rxFirst, 10);
    check("R5 brk tick mode3", brkFirst, 12);
    check("R9 flags cleared", {rdrf, fre, ore, pe}, 4'b0);
    check("R6 rxIrq off", rxIrq, 1'b0);
    tick(1'b1);
    pulseClr();
    clrOnBrk = 1'b0;

    // R8 modes without break support
    for (int m = 1; m <= 2; m++) begin
      opMode = 2'(m);
      lowRun(13);
      check("R8 no break", brkFlag, 1'b0);
      check("R13 capOut gated", capOut, 1'b1);
      check("R8 receiver still runs", rxFirst, 10);
      tick(1'b1);
      pulseAck();
      tick(1'b1);
    end
    opMode = 2'd0;

    // R12 receiver off, break still seen
    rxEn = 1'b0;
    lowRun(13);
    check("R12 no rx flags", {rdrf, fre, ore, pe}, 4'b0);
    check("R12 break tick", brkFirst, 12);
    tick(1'b1);
    pulseClr();

    // R11 one set per low period, re-arm after high
    lowRun(15);
    check("R11 first set", brkFlag, 1'b1);
    pulseClr();
    for (int k = 16; k <= 30; k++) tick(1'b0);
    check("R11 no second set", brkFlag, 1'b0);
    tick(1'b1);
    lowRun(12);
    check("R11 re-armed", brkFirst, 12);

    // R10 set wins over a simultaneous clear
    tick(1'b1);
    for (int k = 1; k <= 11; k++) tick(1'b0);
    tick(1'b0, 1'b1);
    check("R10 set wins", brkFlag, 1'b1);
    brkIntEn = 1'b0;
    @(negedge clk);
    check("R6 brkIrq gated", brkIrq, 1'b0);
    brkIntEn = 1'b1;
    tick(1'b1);
    pulseClr();
    check("R10 final clear", brkFlag, 1'b0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule